// File: doc/BRIEF.md
# Windowed Sun-Spot Centroid Unit

This block finds the centre of a bright spot inside a square tracking window of an image sensor. A sequencer opens each measurement with a strobe that also supplies the window's position on the full array, a background level and a minimum total brightness. The pixels of the window then arrive one at a time, row by row, starting at the top-left corner. Each pixel has the background subtracted and is clamped at zero. The resulting weight is added to a total and to two moment sums, one weighted by column and one weighted by row.

When the last pixel of the window has arrived, the block divides each moment by the total with a sequential restoring divider. It adds the window origin back and reports X and Y as fixed-point array coordinates with a single-cycle valid pulse. If the window is too dark to trust, the block skips the division and reports a lost-sun condition instead. A parameter selects whether the two divisions run on two dividers at once or one after the other on a single shared divider.

Top module: `spot_centroid`

## Requirements
- R1: After reset, `res_valid`, `sun_lost`, `pos_x` and `pos_y` are all zero.
- R2: Each sample is turned into a weight equal to the sample minus the background level latched at the last `frame_go`. The weight is zero whenever the sample is at or below that level.
- R3: The k-th accepted sample of a window (k from 0) lies in column k mod WIN and row k div WIN. `pos_x` equals origin_x·2^FRAC_W + floor(2^FRAC_W·Σ(weight·column) / Σweight), taken modulo 2^(INT_W+FRAC_W).
- R4: `pos_y` follows the same rule as R3 with the row index in place of the column index, and origin_y in place of origin_x.
- R5: Each position is INT_W+FRAC_W bits wide. The upper INT_W bits hold the whole-pixel index and the lower FRAC_W bits hold the fraction in steps of 2^-FRAC_W pixel. An origin near the top of the range wraps modulo 2^(INT_W+FRAC_W).
- R6: If the total weight is zero or below the latched minimum, no division takes place. `res_valid` pulses together with `sun_lost`=1 one cycle after the clock edge that accepts the last sample, and `pos_x`/`pos_y` keep their previous values. A total equal to the minimum is not lost.
- R7: A valid result appears a fixed number of cycles after the clock edge that accepts the last sample. With NUM_W = MOM_W+FRAC_W and MOM_W = clog2(WIN²·(2^PIX_W−1)·(WIN−1)+1), this is NUM_W+2 cycles with two dividers and 2·NUM_W+3 cycles with one shared divider.
- R8: `frame_go` clears the sums and the position counters and latches origin, background and minimum. A `frame_go` in the middle of a window discards the samples already taken. The sample presented in the same cycle as `frame_go` is not taken.
- R9: Samples offered after the WIN·WIN-th one and before the next `frame_go` have no effect on the result.
- R10: A sample is taken only in a cycle with `pix_valid` high. Idle cycles between samples do not change the result.
- R11: `res_valid` is a single-cycle pulse, once per completed window. `sun_lost` is updated with each pulse and holds its value until the next pulse.
- R12: The sums are sized so that a window of WIN·WIN samples at full scale with zero background never overflows, and such a window yields the exact centre.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_go | input | 1 | Start of a window; latches the settings below |
| org_x | input | INT_W (9) | Column of the window's top-left pixel on the array |
| org_y | input | INT_W (9) | Row of the window's top-left pixel on the array |
| bg_level | input | PIX_W (10) | Background level subtracted from every sample |
| min_sum | input | ACC_W (20) | Smallest total weight that counts as sun present |
| pix_valid | input | 1 | Sample qualifier |
| pix_data | input | PIX_W (10) | Pixel sample |
| res_valid | output | 1 | One-cycle result strobe |
| sun_lost | output | 1 | Window too dark; updated with each strobe |
| pos_x | output | INT_W+FRAC_W (15) | Spot centre column, fixed point |
| pos_y | output | INT_W+FRAC_W (15) | Spot centre row, fixed point |

## Verification
The bench builds two copies of the block with a 5×5 window, 4-bit samples, 9 integer bits and 6 fraction bits: one with two dividers and one with a shared divider, both driven by the same inputs. The small window makes it practical to put a single bright pixel at every one of its 25 positions. It also allows many pseudo-random windows with varied backgrounds and origins, and full-scale frames. Because the sums in this configuration are only a few hundred, the bench can pick minimum levels exactly at and just past the total. It also checks both divider latencies and the origin wrap at the top of the 9-bit range.

// File: rtl/spot_pkg.sv
`timescale 1ns/1ps
package spot_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ACCUM = 2'd1,
      ST_DIV_A = 2'd2,
      ST_DIV_B = 2'd3
   } cen_state_t;

endpackage

// File: rtl/bg_clip.sv
`timescale 1ns/1ps
module bg_clip #(
   parameter int PIX_W = 10
) (
   input  logic [PIX_W-1:0] sample,
   input  logic [PIX_W-1:0] floor_lvl,
   output logic [PIX_W-1:0] weight
);

   if (PIX_W < 1) begin : g_bad_pix
      $error("bg_clip: PIX_W must be at least 1");
   end

   always_comb begin
      if (sample > floor_lvl) begin
         weight = sample - floor_lvl;
      end else begin
         weight = '0;
      end
   end

endmodule

// File: rtl/moment_accum.sv
`timescale 1ns/1ps
module moment_accum #(
   parameter int WIN   = 25,
   parameter int PIX_W = 10,
   parameter int ACC_W = 20,
   parameter int MOM_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             in_valid,
   input  logic [PIX_W-1:0] weight,
   output logic [ACC_W-1:0] sum_w,
   output logic [MOM_W-1:0] mom_x,
   output logic [MOM_W-1:0] mom_y,
   output logic             full
);

   localparam int            CW   = (WIN > 1) ? $clog2(WIN) : 1;
   localparam logic [CW-1:0] LAST = CW'(WIN - 1);

   if (ACC_W < PIX_W) begin : g_bad_acc
      $error("moment_accum: ACC_W narrower than a sample");
   end
   if (MOM_W < ACC_W) begin : g_bad_mom
      $error("moment_accum: MOM_W narrower than ACC_W");
   end

   logic [CW-1:0] col_q;
   logic [CW-1:0] row_q;
   logic          take;

   assign take = in_valid && !full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_w <= '0;
         mom_x <= '0;
         mom_y <= '0;
         col_q <= '0;
         row_q <= '0;
         full  <= 1'b0;
      end else if (clear) begin
         sum_w <= '0;
         mom_x <= '0;
         mom_y <= '0;
         col_q <= '0;
         row_q <= '0;
         full  <= 1'b0;
      end else if (take) begin
         sum_w <= sum_w + ACC_W'(weight);
         mom_x <= mom_x + MOM_W'(weight) * MOM_W'(col_q);
         mom_y <= mom_y + MOM_W'(weight) * MOM_W'(row_q);
         if (col_q == LAST) begin
            col_q <= '0;
            if (row_q == LAST) begin
               full <= 1'b1;
            end else begin
               row_q <= row_q + CW'(1);
            end
         end else begin
            col_q <= col_q + CW'(1);
         end
      end
   end

endmodule

// File: rtl/restoring_div.sv
`timescale 1ns/1ps
module restoring_div #(
   parameter int NUM_W = 30,
   parameter int DEN_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NUM_W-1:0] dividend,
   input  logic [DEN_W-1:0] divisor,
   output logic             done,
   output logic [NUM_W-1:0] quotient
);

   localparam int CNT_W = $clog2(NUM_W + 1);

   if (NUM_W < 2) begin : g_bad_num
      $error("restoring_div: NUM_W must be at least 2");
   end

   logic [DEN_W-1:0] den_q;
   logic [DEN_W-1:0] rem_q;
   logic [NUM_W-1:0] sh_q;
   logic [CNT_W-1:0] left_q;
   logic [DEN_W:0]   trial;
   logic [DEN_W:0]   diff;
   logic             fits;

   always_comb begin
      trial = {rem_q, sh_q[NUM_W-1]};
      fits  = trial >= {1'b0, den_q};
      diff  = trial - {1'b0, den_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         den_q  <= '0;
         rem_q  <= '0;
         sh_q   <= '0;
         left_q <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            den_q  <= divisor;
            rem_q  <= '0;
            sh_q   <= dividend;
            left_q <= CNT_W'(NUM_W);
         end else if (left_q != '0) begin
            rem_q  <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
            sh_q   <= {sh_q[NUM_W-2:0], fits};
            left_q <= left_q - CNT_W'(1);
            done   <= (left_q == CNT_W'(1));
         end
      end
   end

   assign quotient = sh_q;

endmodule

// File: rtl/spot_centroid.sv
`timescale 1ns/1ps
module spot_centroid
   import spot_pkg::*;
#(
   parameter  int WIN       = 25,
   parameter  int PIX_W     = 10,
   parameter  int INT_W     = 9,
   parameter  int FRAC_W    = 6,
   parameter  bit SHARE_DIV = 1'b0,
   localparam int POS_W     = INT_W + FRAC_W,
   localparam int ACC_W     = $clog2(longint'(WIN) * WIN * ((longint'(1) << PIX_W) - 1) + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_go,
   input  logic [INT_W-1:0] org_x,
   input  logic [INT_W-1:0] org_y,
   input  logic [PIX_W-1:0] bg_level,
   input  logic [ACC_W-1:0] min_sum,
   input  logic             pix_valid,
   input  logic [PIX_W-1:0] pix_data,
   output logic             res_valid,
   output logic             sun_lost,
   output logic [POS_W-1:0] pos_x,
   output logic [POS_W-1:0] pos_y
);

   localparam int MOM_W = $clog2(longint'(WIN) * WIN * ((longint'(1) << PIX_W) - 1) * (WIN - 1) + 1);
   localparam int NUM_W = MOM_W + FRAC_W;
   localparam int LAT   = SHARE_DIV ? (2 * NUM_W + 3) : (NUM_W + 2);

   // elaboration-time parameter checks
   if (WIN < 2) begin : g_bad_win
      $error("spot_centroid: WIN must be at least 2");
   end
   if (FRAC_W < 1) begin : g_bad_frac
      $error("spot_centroid: FRAC_W must be at least 1");
   end
   if (INT_W < $clog2(WIN)) begin : g_bad_int
      $error("spot_centroid: INT_W cannot index the window");
   end
   if (LAT > 250) begin : g_bad_lat
      $error("spot_centroid: latency too long for the checker counter");
   end

   cen_state_t       state_q;
   logic [INT_W-1:0] org_x_q;
   logic [INT_W-1:0] org_y_q;
   logic [PIX_W-1:0] bg_q;
   logic [ACC_W-1:0] min_q;
   logic [NUM_W-1:0] qx_hold_q;
   logic [POS_W-1:0] pos_x_q;
   logic [POS_W-1:0] pos_y_q;
   logic             res_valid_q;
   logic             sun_lost_q;

   logic [PIX_W-1:0] weight;
   logic [ACC_W-1:0] sum_w;
   logic [MOM_W-1:0] mom_x;
   logic [MOM_W-1:0] mom_y;
   logic             acc_full;
   logic             too_dark;
   logic [NUM_W-1:0] num_x;
   logic [NUM_W-1:0] num_y;
   logic             div_go;
   logic             div_done;
   logic [NUM_W-1:0] q_a;
   logic [NUM_W-1:0] q_b;

   function automatic logic [POS_W-1:0] mk_pos(input logic [INT_W-1:0] org,
                                               input logic [NUM_W-1:0] quo);
      return (POS_W'(org) << FRAC_W) + POS_W'(quo);
   endfunction

   bg_clip #(
      .PIX_W (PIX_W)
   ) u_clip (
      .sample    (pix_data),
      .floor_lvl (bg_q),
      .weight    (weight)
   );

   moment_accum #(
      .WIN   (WIN),
      .PIX_W (PIX_W),
      .ACC_W (ACC_W),
      .MOM_W (MOM_W)
   ) u_accum (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (frame_go),
      .in_valid (pix_valid),
      .weight   (weight),
      .sum_w    (sum_w),
      .mom_x    (mom_x),
      .mom_y    (mom_y),
      .full     (acc_full)
   );

   assign too_dark = (sum_w == '0) || (sum_w < min_q);
   assign num_x    = NUM_W'(mom_x) << FRAC_W;
   assign num_y    = NUM_W'(mom_y) << FRAC_W;

   always_comb begin
      div_go = 1'b0;
      if (!frame_go) begin
         if (state_q == ST_ACCUM && acc_full && !too_dark) begin
            div_go = 1'b1;
         end else if (SHARE_DIV && state_q == ST_DIV_A && div_done) begin
            div_go = 1'b1;
         end
      end
   end

   if (SHARE_DIV == 1'b0) begin : g_par
      logic done_x;
      logic done_y;

      restoring_div #(
         .NUM_W (NUM_W),
         .DEN_W (ACC_W)
      ) u_div_x (
         .clk      (clk),
         .rst_n    (rst_n),
         .start    (div_go),
         .dividend (num_x),
         .divisor  (sum_w),
         .done     (done_x),
         .quotient (q_a)
      );

      restoring_div #(
         .NUM_W (NUM_W),
         .DEN_W (ACC_W)
      ) u_div_y (
         .clk      (clk),
         .rst_n    (rst_n),
         .start    (div_go),
         .dividend (num_y),
         .divisor  (sum_w),
         .done     (done_y),
         .quotient (q_b)
      );

      assign div_done = done_x & done_y;
   end else begin : g_shr
      logic [NUM_W-1:0] num_sel;

      // first pass from the accumulate state divides X, second pass divides Y
      assign num_sel = (state_q == ST_DIV_A) ? num_y : num_x;

      restoring_div #(
         .NUM_W (NUM_W),
         .DEN_W (ACC_W)
      ) u_div (
         .clk      (clk),
         .rst_n    (rst_n),
         .start    (div_go),
         .dividend (num_sel),
         .divisor  (sum_w),
         .done     (div_done),
         .quotient (q_a)
      );

      assign q_b = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         org_x_q     <= '0;
         org_y_q     <= '0;
         bg_q        <= '0;
         min_q       <= '0;
         qx_hold_q   <= '0;
         pos_x_q     <= '0;
         pos_y_q     <= '0;
         res_valid_q <= 1'b0;
         sun_lost_q  <= 1'b0;
      end else begin
         res_valid_q <= 1'b0;
         if (frame_go) begin
            org_x_q <= org_x;
            org_y_q <= org_y;
            bg_q    <= bg_level;
            min_q   <= min_sum;
            state_q <= ST_ACCUM;
         end else begin
            case (state_q)
               ST_ACCUM: begin
                  if (acc_full) begin
                     if (too_dark) begin
                        res_valid_q <= 1'b1;
                        sun_lost_q  <= 1'b1;
                        state_q     <= ST_IDLE;
                     end else begin
                        state_q <= ST_DIV_A;
                     end
                  end
               end
               ST_DIV_A: begin
                  if (div_done) begin
                     if (SHARE_DIV) begin
                        qx_hold_q <= q_a;
                        state_q   <= ST_DIV_B;
                     end else begin
                        pos_x_q     <= mk_pos(org_x_q, q_a);
                        pos_y_q     <= mk_pos(org_y_q, q_b);
                        res_valid_q <= 1'b1;
                        sun_lost_q  <= 1'b0;
                        state_q     <= ST_IDLE;
                     end
                  end
               end
               ST_DIV_B: begin
                  if (div_done) begin
                     pos_x_q     <= mk_pos(org_x_q, qx_hold_q);
                     pos_y_q     <= mk_pos(org_y_q, q_a);
                     res_valid_q <= 1'b1;
                     sun_lost_q  <= 1'b0;
                     state_q     <= ST_IDLE;
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign res_valid = res_valid_q;
   assign sun_lost  = sun_lost_q;
   assign pos_x     = pos_x_q;
   assign pos_y     = pos_y_q;

endmodule

// File: rtl/spot_centroid_chk.sv
`timescale 1ns/1ps
module spot_centroid_chk #(
   parameter  int WIN    = 25,
   parameter  int INT_W  = 9,
   parameter  int FRAC_W = 6,
   parameter  int ACC_W  = 20,
   parameter  int LAT    = 32,
   localparam int POS_W  = INT_W + FRAC_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frame_go,
   input logic             pix_valid,
   input logic             full,
   input logic [ACC_W-1:0] sum_w,
   input logic [INT_W-1:0] org_x,
   input logic [INT_W-1:0] org_y,
   input logic             res_valid,
   input logic             sun_lost,
   input logic [POS_W-1:0] pos_x,
   input logic [POS_W-1:0] pos_y
);

   localparam logic [POS_W-1:0] SPAN = POS_W'((WIN - 1) << FRAC_W);

   logic [7:0] since_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_q <= '0;
      end else if (frame_go) begin
         since_q <= '0;
      end else if (full) begin
         if (since_q != 8'hFF) begin
            since_q <= since_q + 8'd1;
         end
      end else begin
         since_q <= '0;
      end
   end

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);  // R11

   AST_LOST_HOLDS_POS: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && sun_lost) |-> ($stable(pos_x) && $stable(pos_y)));  // R6

   AST_LOST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && sun_lost) |-> (since_q == 8'd1));  // R6

   AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !sun_lost) |-> (since_q == 8'(LAT)));  // R7

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(frame_go) |-> (sum_w >= $past(sum_w)));  // R12

   AST_X_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !sun_lost) |-> (POS_W'(pos_x - (POS_W'(org_x) << FRAC_W)) <= SPAN));  // R3

   AST_Y_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !sun_lost) |-> (POS_W'(pos_y - (POS_W'(org_y) << FRAC_W)) <= SPAN));  // R4

   AST_EXTRA_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (full && pix_valid && !frame_go) |=> $stable(sum_w));  // R9

endmodule

bind spot_centroid spot_centroid_chk #(
   .WIN    (WIN),
   .INT_W  (INT_W),
   .FRAC_W (FRAC_W),
   .ACC_W  (ACC_W),
   .LAT    (LAT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .frame_go  (frame_go),
   .pix_valid (pix_valid),
   .full      (acc_full),
   .sum_w     (sum_w),
   .org_x     (org_x_q),
   .org_y     (org_y_q),
   .res_valid (res_valid),
   .sun_lost  (sun_lost),
   .pos_x     (pos_x),
   .pos_y     (pos_y)
);

// File: tb/spot_centroid_bench.sv
`timescale 1ns/1ps
module spot_centroid_bench;

   localparam int WIN    = 5;
   localparam int PIX_W  = 4;
   localparam int INT_W  = 9;
   localparam int FRAC_W = 6;
   localparam int POS_W  = INT_W + FRAC_W;
   localparam int NPIX   = WIN * WIN;
   localparam int PMAX   = (1 << PIX_W) - 1;
   localparam int ACC_W  = $clog2(NPIX * PMAX + 1);
   localparam int MOM_W  = $clog2(NPIX * PMAX * (WIN - 1) + 1);
   localparam int NUMW   = MOM_W + FRAC_W;
   localparam int LAT_P  = NUMW + 2;
   localparam int LAT_S  = 2 * NUMW + 3;
   localparam int WRAP   = 1 << POS_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             frame_go = 1'b0;
   logic [INT_W-1:0] org_x = '0;
   logic [INT_W-1:0] org_y = '0;
   logic [PIX_W-1:0] bg_level = '0;
   logic [ACC_W-1:0] min_sum = '0;
   logic             pix_valid = 1'b0;
   logic [PIX_W-1:0] pix_data = '0;

   logic             rv_p, sl_p, rv_s, sl_s;
   logic [POS_W-1:0] px_p, py_p, px_s, py_s;

   always #5 clk = ~clk;

   spot_centroid #(.WIN(WIN), .PIX_W(PIX_W), .INT_W(INT_W), .FRAC_W(FRAC_W), .SHARE_DIV(1'b0)) u_spot_centroid (
      .clk(clk), .rst_n(rst_n), .frame_go(frame_go), .org_x(org_x), .org_y(org_y),
      .bg_level(bg_level), .min_sum(min_sum), .pix_valid(pix_valid), .pix_data(pix_data),
      .res_valid(rv_p), .sun_lost(sl_p), .pos_x(px_p), .pos_y(py_p));

   spot_centroid #(.WIN(WIN), .PIX_W(PIX_W), .INT_W(INT_W), .FRAC_W(FRAC_W), .SHARE_DIV(1'b1)) u_spot_centroid_seq (
      .clk(clk), .rst_n(rst_n), .frame_go(frame_go), .org_x(org_x), .org_y(org_y),
      .bg_level(bg_level), .min_sum(min_sum), .pix_valid(pix_valid), .pix_data(pix_data),
      .res_valid(rv_s), .sun_lost(sl_s), .pos_x(px_s), .pos_y(py_s));

   int             errors = 0;
   int             checks = 0;
   bit             finished = 1'b0;
   int             exp_px = 0;
   int             exp_py = 0;
   int             frame [NPIX];
   logic [15:0]    lfsr = 16'hACE1;

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   function automatic logic [15:0] step(input logic [15:0] v);
      return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
   endfunction

   function automatic int total_w(input int bg);
      int s = 0;
      for (int k = 0; k < NPIX; k++) s += (frame[k] > bg) ? frame[k] - bg : 0;
      return s;
   endfunction

   task automatic run_frame(input int ox, input int oy, input int bg, input int mn,
                            input int pre, input int extra, input int gap, input string tag);
      int  s, sx, sy, w, ex, ey, ext;
      bit  lost;
      int  first_p, first_s, cnt_p, cnt_s;
      int  cx_p, cy_p, cx_s, cy_s;
      bit  cl_p, cl_s;
      s = 0; sx = 0; sy = 0;
      for (int k = 0; k < NPIX; k++) begin
         w = (frame[k] > bg) ? frame[k] - bg : 0;
         s += w; sx += w * (k % WIN); sy += w * (k / WIN);
      end
      lost = (s == 0) || (s < mn);
      if (lost) begin
         ex = exp_px; ey = exp_py;
      end else begin
         ex = (ox * (1 << FRAC_W) + (sx * (1 << FRAC_W)) / s) % WRAP;
         ey = (oy * (1 << FRAC_W) + (sy * (1 << FRAC_W)) / s) % WRAP;
      end
      @(negedge clk);
      pix_valid = 1'b0; frame_go = 1'b1;
      org_x = INT_W'(ox); org_y = INT_W'(oy); bg_level = PIX_W'(bg); min_sum = ACC_W'(mn);
      @(negedge clk);
      frame_go = 1'b0;
      if (pre > 0) begin
         for (int i = 0; i < pre; i++) begin
            pix_valid = 1'b1; pix_data = PIX_W'(PMAX);
            @(negedge clk);
         end
         pix_valid = 1'b0; frame_go = 1'b1;
         @(negedge clk);
         frame_go = 1'b0;
      end
      for (int k = 0; k < NPIX; k++) begin
         pix_valid = 1'b1; pix_data = PIX_W'(frame[k]);
         if (k < NPIX - 1) begin
            @(negedge clk);
            if (gap != 0 && (k % 3) == 0) begin
               pix_valid = 1'b0;
               @(negedge clk);
            end
         end
      end
      first_p = -1; first_s = -1; cnt_p = 0; cnt_s = 0;
      cx_p = 0; cy_p = 0; cx_s = 0; cy_s = 0; cl_p = 1'b0; cl_s = 1'b0;
      ext = extra;
      for (int c = 0; c <= LAT_S + 4; c++) begin
         @(posedge clk);
         @(negedge clk);
         if (rv_p) begin
            cnt_p++;
            if (first_p < 0) begin first_p = c; cx_p = int'(px_p); cy_p = int'(py_p); cl_p = sl_p; end
         end
         if (rv_s) begin
            cnt_s++;
            if (first_s < 0) begin first_s = c; cx_s = int'(px_s); cy_s = int'(py_s); cl_s = sl_s; end
         end
         if (ext > 0) begin
            pix_valid = 1'b1; pix_data = PIX_W'(PMAX); ext--;
         end else begin
            pix_valid = 1'b0;
         end
      end
      chk(first_p == (lost ? 1 : LAT_P), $sformatf("R7 parallel latency (%s)", tag), first_p, lost ? 1 : LAT_P);
      chk(first_s == (lost ? 1 : LAT_S), $sformatf("R7 shared latency (%s)", tag), first_s, lost ? 1 : LAT_S);
      chk(cnt_p == 1 && cnt_s == 1, $sformatf("R11 one pulse (%s)", tag), cnt_p + cnt_s, 2);
      chk(cl_p == lost && cl_s == lost, $sformatf("R6 lost flag (%s)", tag), int'(cl_p) + int'(cl_s), lost ? 2 : 0);
      chk(sl_p == lost && sl_s == lost, $sformatf("R11 flag held (%s)", tag), int'(sl_p) + int'(sl_s), lost ? 2 : 0);
      chk(cx_p == ex, $sformatf("R3 pos_x parallel (%s)", tag), cx_p, ex);
      chk(cx_s == ex, $sformatf("R3 pos_x shared (%s)", tag), cx_s, ex);
      chk(cy_p == ey, $sformatf("R4 pos_y parallel (%s)", tag), cy_p, ey);
      chk(cy_s == ey, $sformatf("R4 pos_y shared (%s)", tag), cy_s, ey);
      exp_px = ex; exp_py = ey;
   endtask

   initial begin
      #1500000;
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual=1 expected=0");
         report();
         $finish;
      end
   end

   initial begin
      int s;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(rv_p == 1'b0 && rv_s == 1'b0, "R1 res_valid after reset", int'(rv_p) + int'(rv_s), 0);
      chk(sl_p == 1'b0 && sl_s == 1'b0, "R1 sun_lost after reset", int'(sl_p) + int'(sl_s), 0);
      chk(px_p == '0 && px_s == '0, "R1 pos_x after reset", int'(px_p) + int'(px_s), 0);
      chk(py_p == '0 && py_s == '0, "R1 pos_y after reset", int'(py_p) + int'(py_s), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 R4 R5: a single bright pixel at every window position
      for (int p = 0; p < NPIX; p++) begin
         for (int k = 0; k < NPIX; k++) frame[k] = (k == p) ? PMAX : 0;
         run_frame((p * 37) % 480, 10 + p * 3, 0, 1, 0, 0, 0, $sformatf("R5 single pixel %0d", p));
      end

      // R12: full-scale uniform window, exact centre
      for (int k = 0; k < NPIX; k++) frame[k] = PMAX;
      run_frame(100, 200, 0, 1, 0, 0, 0, "R12 full scale");

      // R2: background clamps dark pixels to zero weight
      for (int k = 0; k < NPIX; k++) frame[k] = (k == 7) ? 12 : 3;
      run_frame(40, 50, 5, 1, 0, 0, 0, "R2 clamp");
      for (int k = 0; k < NPIX; k++) frame[k] = (k % 2 == 0) ? 9 : 2;
      run_frame(41, 52, 2, 1, 0, 0, 0, "R2 partial background");

      // pseudo-random windows with varied background and origin
      for (int f = 0; f < 24; f++) begin
         for (int k = 0; k < NPIX; k++) begin
            lfsr = step(lfsr);
            frame[k] = int'(lfsr[3:0]);
         end
         lfsr = step(lfsr);
         run_frame(int'(lfsr[8:0]) % 480, int'(lfsr[15:7]) % 480, int'(lfsr[1:0]), 1, 0, 0, 0,
                   $sformatf("R2 random %0d", f));
      end

      // R6: threshold boundary and all-dark window
      for (int k = 0; k < NPIX; k++) frame[k] = (k >= 10 && k < 15) ? 6 : 1;
      s = total_w(1);
      run_frame(60, 70, 1, s, 0, 0, 0, "R6 total equals minimum");
      run_frame(61, 71, 1, s + 1, 0, 0, 0, "R6 total below minimum");
      for (int k = 0; k < NPIX; k++) frame[k] = 4;
      run_frame(62, 72, 4, 0, 0, 0, 0, "R6 zero total");
      for (int k = 0; k < NPIX; k++) frame[k] = (k == 18) ? 10 : 0;
      run_frame(63, 73, 0, 1, 0, 0, 0, "R6 recovery");

      // R8: restart in mid-window discards earlier samples
      for (int k = 0; k < NPIX; k++) frame[k] = (k == 20) ? 8 : 0;
      run_frame(80, 90, 0, 1, 10, 0, 0, "R8 restart");

      // R9: samples beyond the window are ignored
      for (int k = 0; k < NPIX; k++) frame[k] = (k == 1) ? 7 : 0;
      run_frame(81, 91, 0, 1, 0, 8, 0, "R9 extra samples");

      // R10: idle cycles between samples
      for (int k = 0; k < NPIX; k++) frame[k] = (k + 3) % 16;
      run_frame(82, 92, 0, 1, 0, 0, 1, "R10 gaps");

      // R5: origin at the top of the range wraps
      for (int k = 0; k < NPIX; k++) frame[k] = (k == NPIX - 1) ? 9 : 0;
      run_frame(511, 500, 0, 1, 0, 0, 0, "R5 origin wrap");

      finished = 1'b1;
      report();
      $finish;
   end

endmodule